// File: doc/BRIEF.md
# Parallel Write Strobe Qualifier

This block sits behind the asynchronous parallel bus of a byte-wide nonvolatile memory. It samples chip select, write enable and output enable with a fast system clock and turns each legal bus write into a single-cycle write event. The event carries the address that was on the bus when the write began and the data that was on the bus when it ended. Downstream page-programming logic takes the event to store the byte. It takes a separate byte-load pulse to restart its page timer.

A write starts when the later of the two active-low strobes falls while output enable is high. It ends when the earlier of them rises. Low periods that are too short count as glitches and are dropped. Writes are blocked while the supply-good input is low, and for a fixed number of cycles after it rises. A write that is in progress when the supply fails is discarded.

Top module: `wr_strobe_qual`

## Requirements
- R1: A write starts only in a sampled cycle where `csN` and `weN` are both low, were not both low in the previous sampled cycle, and `oeN` is high.
- R2: `wrAddr` takes the value of `addrIn` sampled in the cycle the write starts, whichever strobe fell last, and keeps it until the next start.
- R3: `wrData` takes the value of `dataIn` sampled in the first cycle where either strobe is seen high again after a qualified write.
- R4: Low `oeN` at the start cycle, or only one strobe low, starts no write. Both strobes already low when `oeN` rises also start none.
- R5: A write qualifies only if both strobes stay low and `oeN` stays high for at least MIN_LOW consecutive sampled cycles, counting the start cycle. A shorter low period produces no event.
- R6: While `supplyGood` is low, no write starts.
- R7: After `supplyGood` rises, writes are allowed only once it has been sampled high for PWR_DLY consecutive cycles before the start cycle.
- R8: If `supplyGood` falls while a write is filtering or qualified, that write is dropped and produces no `wrEvent`.
- R9: Each qualified write that ends produces exactly one one-cycle `wrEvent`. It is high in the cycle after the third rising clock edge that samples the ending strobe level.
- R10: `byteLoad` pulses for one cycle, once per write, when the write qualifies, with the same input-to-output latency as `wrEvent`.
- R11: After reset, `wrEvent`, `byteLoad`, `wrAddr` and `wrData` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyGood | input | 1 | High while the supply is within range |
| csN | input | 1 | Bus chip select, active low |
| weN | input | 1 | Bus write enable, active low |
| oeN | input | 1 | Bus output enable, active low |
| addrIn | input | ADDR_W | Bus address |
| dataIn | input | DATA_W | Bus write data |
| wrEvent | output | 1 | One-cycle pulse per completed write |
| wrAddr | output | ADDR_W | Address captured at the write start |
| wrData | output | DATA_W | Data captured at the write end |
| byteLoad | output | 1 | One-cycle pulse when a write qualifies |

## Verification
The hardest case to reach is a write that has passed the glitch filter and is then cut off by a supply drop. After that, the lockout must hold off the next write for the full power-on delay. The stimulus opens a qualified write and pulls `supplyGood` low for a single cycle while both strobes are still low. It then tries a write at once, and again after the delay has run out. Glitch rejection is probed with low periods one cycle shorter than the threshold and exactly at it. A reference model in the bench tracks every sampled cycle and checks the outputs on every clock.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILTER, ST_ACTIVE} wsqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic capAddr;   // write started: latch address
    logic capData;   // write ended: latch data, fire event
    logic qualify;   // write passed the glitch filter
  } wsqStrobe_t;
endpackage

// File: rtl/wsq_ctrl.sv
module wsq_ctrl
  import wsq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2,
  parameter int PWR_DLY     = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       weN,
  input  logic       oeN,
  input  logic       supplyGood,
  output wsqStrobe_t strb
);
  localparam int LOW_W = $clog2(MIN_LOW + 1);
  localparam int PWR_W = $clog2(PWR_DLY + 1);

  logic [SYNC_STAGES-1:0] csSh, weSh, oeSh, sgSh;
  logic csS, weS, oeS, sgS;
  logic bothLow, prevLow, unlocked, startHit;
  logic [PWR_W-1:0] pwrCnt;
  logic [LOW_W-1:0] lowCnt, lowNext;
  wsqState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSh <= '1;
      weSh <= '1;
      oeSh <= '1;
      sgSh <= '0;
    end else begin
      csSh <= {csSh[SYNC_STAGES-2:0], csN};
      weSh <= {weSh[SYNC_STAGES-2:0], weN};
      oeSh <= {oeSh[SYNC_STAGES-2:0], oeN};
      sgSh <= {sgSh[SYNC_STAGES-2:0], supplyGood};
    end
  end

  assign csS = csSh[SYNC_STAGES-1];
  assign weS = weSh[SYNC_STAGES-1];
  assign oeS = oeSh[SYNC_STAGES-1];
  assign sgS = sgSh[SYNC_STAGES-1];

  assign bothLow  = ~csS & ~weS;
  assign unlocked = sgS && (pwrCnt == PWR_W'(PWR_DLY));
  assign startHit = bothLow && !prevLow && oeS && unlocked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrCnt  <= '0;
      prevLow <= 1'b0;
      state   <= ST_IDLE;
      lowCnt  <= '0;
    end else begin
      if (!sgS)
        pwrCnt <= '0;
      else if (pwrCnt != PWR_W'(PWR_DLY))
        pwrCnt <= pwrCnt + PWR_W'(1);
      prevLow <= bothLow;
      state   <= nextState;
      lowCnt  <= lowNext;
    end
  end

  always_comb begin
    nextState = state;
    lowNext   = lowCnt;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (startHit) begin
          strb.capAddr = 1'b1;
          if (MIN_LOW <= 1) begin
            nextState    = ST_ACTIVE;
            strb.qualify = 1'b1;
          end else begin
            nextState = ST_FILTER;
            lowNext   = LOW_W'(1);
          end
        end
      end
      ST_FILTER: begin
        if (!unlocked || !oeS || !bothLow) begin
          nextState = ST_IDLE;
        end else if (int'(lowCnt) + 1 >= MIN_LOW) begin
          nextState    = ST_ACTIVE;
          strb.qualify = 1'b1;
        end else begin
          lowNext = lowCnt + LOW_W'(1);
        end
      end
      ST_ACTIVE: begin
        if (!unlocked) begin
          nextState = ST_IDLE;
        end else if (!bothLow) begin
          strb.capData = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // leaving idle requires the start conditions in the previous cycle
  assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && $past(state) == ST_IDLE) |-> $past(oeS && bothLow && !prevLow));

  // entering active requires strobes still low one cycle before
  assert_filter_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && $past(state) != ST_ACTIVE) |-> $past(bothLow));

  // a qualified write only exists after the power-on counter expired
  assert_lockout_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE) |-> (pwrCnt == PWR_W'(PWR_DLY)));

  // supply loss always returns control to idle
  assert_supply_abort_R8: assert property (@(posedge clk) disable iff (!rstN)
    !sgS |=> (state == ST_IDLE));
endmodule

// File: rtl/wsq_dpath.sv
module wsq_dpath
  import wsq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  wsqStrobe_t        strb,
  output logic              wrEvent,
  output logic              byteLoad,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);
  // delay bus values to line up with the synchronised strobes
  logic [SYNC_STAGES-1:0][ADDR_W-1:0] addrPipe;
  logic [SYNC_STAGES-1:0][DATA_W-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrPipe <= '0;
      dataPipe <= '0;
      wrAddr   <= '0;
      wrData   <= '0;
      wrEvent  <= 1'b0;
      byteLoad <= 1'b0;
    end else begin
      addrPipe <= {addrPipe[SYNC_STAGES-2:0], addrIn};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], dataIn};
      if (strb.capAddr) wrAddr <= addrPipe[SYNC_STAGES-1];
      if (strb.capData) wrData <= dataPipe[SYNC_STAGES-1];
      wrEvent  <= strb.capData;
      byteLoad <= strb.qualify;
    end
  end

  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrEvent |=> !wrEvent);

  assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrEvent |-> $stable(wrAddr));

  assert_load_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    byteLoad |=> !byteLoad);
endmodule

// File: rtl/wr_strobe_qual.sv
module wr_strobe_qual
  import wsq_pkg::*;
#(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 2,
  parameter int PWR_DLY     = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyGood,
  input  logic              csN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              wrEvent,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              byteLoad
);
  wsqStrobe_t strb;

  wsq_ctrl #(
    .SYNC_STAGES(SYNC_STAGES), .MIN_LOW(MIN_LOW), .PWR_DLY(PWR_DLY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .weN(weN), .oeN(oeN),
    .supplyGood(supplyGood), .strb(strb)
  );

  wsq_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .strb(strb),
    .wrEvent(wrEvent), .byteLoad(byteLoad), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/wr_strobe_qual_tb.sv
module wr_strobe_qual_tb;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int MINL = 3;
  localparam int PDLY = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sg = 1'b0, csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic wrEvent, byteLoad;
  logic [AW-1:0] wrAddr;
  logic [DW-1:0] wrData;

  int tests = 0, fails = 0, evCnt = 0, blCnt = 0, cycles = 0;
  string curReq = "R11";

  always #5 clk = ~clk;

  wr_strobe_qual #(.ADDR_W(AW), .DATA_W(DW), .MIN_LOW(MINL), .PWR_DLY(PDLY)) u_dut (
    .clk(clk), .rstN(rstN), .supplyGood(sg), .csN(csN), .weN(weN), .oeN(oeN),
    .addrIn(addr), .dataIn(data), .wrEvent(wrEvent), .wrAddr(wrAddr),
    .wrData(wrData), .byteLoad(byteLoad)
  );

  // behavioural reference: state 0 idle, 1 filtering, 2 qualified
  int mState = 0, mN = 0, mRun = 0;
  bit mPrev = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mData = '0;
  // expected outputs per sample, three samples deep
  logic [AW+DW+1:0] expQ [$];

  initial begin
    for (int i = 0; i < 3; i++) expQ.push_back('0);
  end

  always @(posedge clk) begin
    if (rstN) begin
      bit low, ok, ev, bl;
      low = !csN && !weN;
      ok = sg && (mRun >= PDLY);
      ev = 0; bl = 0;
      case (mState)
        0: if (low && !mPrev && !oeN == 0 && ok) begin
             mAddr = addr;
             mN = 1;
             if (mN >= MINL) begin mState = 2; bl = 1; end else mState = 1;
           end
        1: if (!ok || oeN == 0 || !low) mState = 0;
           else begin
             mN++;
             if (mN >= MINL) begin mState = 2; bl = 1; end
           end
        default: if (!ok) mState = 0;
                 else if (!low) begin mData = data; ev = 1; mState = 0; end
      endcase
      mPrev = low;
      mRun = sg ? ((mRun < PDLY) ? mRun + 1 : PDLY) : 0;
      expQ.push_back({ev, bl, mAddr, mData});
      void'(expQ.pop_front());
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      logic [AW+DW+1:0] e;
      e = expQ[0];
      tests++;
      if ({wrEvent, byteLoad, wrAddr, wrData} !== e) begin
        fails++;
        $display("FAIL %s model: got ev=%0b bl=%0b a=%h d=%h exp ev=%0b bl=%0b a=%h d=%h",
                 curReq, wrEvent, byteLoad, wrAddr, wrData,
                 e[AW+DW+1], e[AW+DW], e[AW+DW-1:DW], e[DW-1:0]);
      end
      if (wrEvent) evCnt++;
      if (byteLoad) blCnt++;
    end
  end

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got %0d cycles exp < 100000", cycles);
      report();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", tag, got, exp);
    end
  endtask

  // both strobes fall together, held low for len sampled cycles
  task automatic pulse(int len, logic [AW-1:0] a, logic [DW-1:0] d);
    addr = a; data = d;
    csN = 0; weN = 0;
    idle(len);
    csN = 1; weN = 1;
    idle(6);
  endtask

  initial begin
    int base, bbase;
    idle(4);
    rstN = 1;
    idle(1);
    // R11 reset state
    check("R11 wrEvent", int'(wrEvent), 0);
    check("R11 byteLoad", int'(byteLoad), 0);
    check("R11 wrAddr", int'(wrAddr), 0);
    check("R11 wrData", int'(wrData), 0);

    // R6 supply low inhibits
    curReq = "R6"; base = evCnt;
    pulse(6, 15'h0101, 8'h01);
    check("R6 events", evCnt - base, 0);

    // R7 lockout after supply rises
    curReq = "R7"; sg = 1; base = evCnt;
    idle(3);
    pulse(6, 15'h0202, 8'h02);
    check("R7 events in lockout", evCnt - base, 0);
    idle(50);

    // R2 R3 write-enable controlled, address moves after start
    curReq = "R2"; base = evCnt;
    addr = 15'h1234; data = 8'h5A;
    csN = 0; idle(2);
    weN = 0; idle(1);
    addr = 15'h7FFF; idle(3);
    data = 8'hC3; idle(1);
    weN = 1; idle(1);
    data = 8'h00; idle(1);
    csN = 1; idle(6);
    check("R9 events WE-ctrl", evCnt - base, 1);
    check("R2 wrAddr WE-ctrl", int'(wrAddr), 'h1234);
    check("R3 wrData WE-ctrl", int'(wrData), 'hC3);

    // R2 R3 chip-select controlled
    curReq = "R3"; base = evCnt;
    addr = 15'h0ABC; data = 8'h11;
    weN = 0; idle(2);
    csN = 0; idle(1);
    addr = 15'h0000; idle(4);
    data = 8'h96; idle(1);
    csN = 1; idle(1);
    data = 8'h00; idle(1);
    weN = 1; idle(6);
    check("R1 events CS-ctrl", evCnt - base, 1);
    check("R2 wrAddr CS-ctrl", int'(wrAddr), 'h0ABC);
    check("R3 wrData CS-ctrl", int'(wrData), 'h96);

    // R4 inhibit cases
    curReq = "R4"; base = evCnt;
    oeN = 0;
    pulse(6, 15'h0303, 8'h03);
    csN = 0; weN = 0; idle(2);
    oeN = 1; idle(5);
    csN = 1; weN = 1; idle(4);
    csN = 0; idle(8); csN = 1; idle(4);
    weN = 0; idle(8); weN = 1; idle(4);
    check("R4 events inhibited", evCnt - base, 0);

    // R5 R10 glitch filter boundary
    curReq = "R5"; base = evCnt; bbase = blCnt;
    pulse(MINL - 1, 15'h0404, 8'h04);
    check("R5 short pulse events", evCnt - base, 0);
    check("R10 short pulse loads", blCnt - bbase, 0);
    pulse(MINL, 15'h0505, 8'h55);
    check("R5 exact pulse events", evCnt - base, 1);
    check("R10 exact pulse loads", blCnt - bbase, 1);
    check("R3 exact pulse data", int'(wrData), 'h55);

    // R8 supply drop during qualified write
    curReq = "R8"; base = evCnt; bbase = blCnt;
    addr = 15'h0606; data = 8'h66;
    csN = 0; weN = 0; idle(5);
    sg = 0; idle(1);
    sg = 1; idle(2);
    csN = 1; weN = 1; idle(6);
    check("R8 events after drop", evCnt - base, 0);
    check("R10 load before drop", blCnt - bbase, 1);
    curReq = "R7";
    pulse(5, 15'h0707, 8'h77);
    check("R7 relock events", evCnt - base, 0);
    idle(50);

    // R9 back-to-back writes, one pulse each
    curReq = "R9"; base = evCnt;
    for (int k = 0; k < 3; k++) pulse(4, AW'(16 + k), DW'(8'hA0 + k));
    check("R9 three writes", evCnt - base, 3);
    check("R9 last data", int'(wrData), 'hA2);
    check("R9 last addr", int'(wrAddr), 18);

    idle(5);
    report();
  end
endmodule